// File: doc/BRIEF.md
# Six-Stage CIC Decimator with Gain Normalization

This block takes a 14-bit two's-complement sample on every clock and reduces the rate by a fixed factor of 125 using a six-stage cascaded integrator-comb filter. At a 125 MHz sample clock it produces one output sample per microsecond. Six integrators accumulate at the full input rate. A modulo-125 counter raises a decimation strobe once per 125 accepted samples, and six single-delay comb stages difference the integrator result only on that strobe.

The comb result carries a DC gain of 125^6, about 3.8e12. It is brought back to the input range by one constant multiply and one arithmetic shift, `(comb * 302231) >>> 60`. This is floor rounding, with an effective gain just under one. The normalized value is clipped to the 14-bit signed range and registered, together with a one-cycle valid pulse.

When the filter enable is low, the filter state is held cleared and the output register copies the input on every cycle with valid held high. This gives an unfiltered path with the same single-register latency.

Top module: `cicdec_top`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `dout` is 0 and `dout_vld` is 0.
- R2: In filter mode, number the samples accepted at enabled clock edges k = 0, 1, 2, … from reset release or from the first edge with `cic_en` high. For every k with k mod 125 = 124, `dout_vld` is high for exactly the one cycle after edge k+1. In filter mode it is low at all other times.
- R3: With a constant input c held long enough to settle, the output equals floor(c·125^6·302231 / 2^60). This is c−1 for c > 0 and c for c ≤ 0.
- R4: The output for strobe sample k equals floor(y·302231 / 2^60), clipped to [−8192, 8191]. Here y is the input passed through six cascaded 125-sample running sums (each sum includes the newest sample, with zero history at the start), taken at sample k−6. Between strobes the comb result holds its value.
- R5: Integrators wrap modulo 2^64 with no saturation. A full-scale input of −8192, held for thousands of cycles (far past the point where the integrators wrap), still gives correct outputs.
- R6: When `cic_en` is low at a clock edge, `dout` takes that edge's `din` and `dout_vld` is high after the edge.
- R7: While `cic_en` is low, the integrators, combs, pending result and decimation phase are cleared. After re-enable, the output timing and values follow R2 and R4 from a fresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one input sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cic_en | input | 1 | 1: filter and decimate; 0: registered pass-through |
| din | input | 14 | Signed input sample |
| dout | output | 14 | Signed filtered (or passed-through) sample |
| dout_vld | output | 1 | One-cycle pulse per output sample; held high in pass-through |

## Verification
The bench holds full-scale −8192 for over three thousand cycles so that the integrators wrap. A design that saturated or narrowed them would drift away from the bounded running-sum model. Negative constants check floor rounding: a shift that truncated toward zero would return −999 where −1000 is due. Each filter run begins right after a pass-through stretch, so a counter or comb delay that kept its state across the disable would move the first pulse or corrupt the first outputs. Every pulse is matched to its exact due cycle, so a strobe decode or pipeline stage off by one shows up as a spurious or missing valid.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Default geometry of the decimator
  localparam int unsigned CIC_IN_W   = 14;
  localparam int unsigned CIC_ACC_W  = 64;
  localparam int unsigned CIC_STAGES = 6;
  localparam int unsigned CIC_RATIO  = 125;
  // Gain removal: multiply then arithmetic right shift, approximating 2^SHIFT / RATIO^STAGES
  localparam int unsigned CIC_NORM_MUL   = 302231;
  localparam int unsigned CIC_NORM_SHIFT = 60;
endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int unsigned IN_W  = 14,
  parameter int unsigned ACC_W = 64,
  parameter int unsigned N     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IN_W-1:0]  din,
  output logic [ACC_W-1:0] acc_out
);
  localparam int unsigned EXT_W = ACC_W - IN_W;

  logic [ACC_W-1:0] tap [N+1];

  assign tap[0]  = {{EXT_W{din[IN_W-1]}}, din};
  assign acc_out = tap[N];

  for (genvar g = 0; g < N; g++) begin : g_stage
    logic [ACC_W-1:0] acc_r;
    // modulo-2^ACC_W accumulation; wrap is undone by the combs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_r <= '0;
      else if (!run)   acc_r <= '0;
      else             acc_r <= acc_r + tap[g];
    end
    assign tap[g+1] = acc_r;
  end
endmodule

// File: rtl/cic_dec_ctr.sv
module cic_dec_ctr #(
  parameter int unsigned R = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic stb
);
  localparam int unsigned CW = (R > 1) ? $clog2(R) : 1;
  localparam logic [CW-1:0] LAST = CW'(R - 1);

  logic [CW-1:0] phase;

  assign stb = run && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (!run || stb) phase <= '0;
    else                 phase <= phase + 1'b1;
  end
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned N     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             stb,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] comb_q,
  output logic             comb_vld
);
  logic [ACC_W-1:0] diff [N+1];

  assign diff[0] = acc_in;

  for (genvar g = 0; g < N; g++) begin : g_stage
    logic [ACC_W-1:0] dly_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dly_r <= '0;
      else if (!run)       dly_r <= '0;
      else if (stb)        dly_r <= diff[g];
    end
    assign diff[g+1] = diff[g] - dly_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comb_q   <= '0;
      comb_vld <= 1'b0;
    end else if (!run) begin
      comb_q   <= '0;
      comb_vld <= 1'b0;
    end else begin
      comb_vld <= stb;
      if (stb) comb_q <= diff[N];
    end
  end
endmodule

// File: rtl/cic_scale.sv
module cic_scale #(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned OUT_W = 14,
  parameter int unsigned MUL   = 302231,
  parameter int unsigned SHIFT = 60
) (
  input  logic [ACC_W-1:0] v,
  output logic [OUT_W-1:0] y
);
  localparam int unsigned MUL_W = $clog2(MUL + 1) + 1;
  localparam int unsigned PW    = ACC_W + MUL_W;
  localparam logic signed [MUL_W-1:0] MUL_C = MUL_W'(MUL);

  // floor((v * MUL) / 2^SHIFT), clipped to the signed OUT_W range
  function automatic logic [OUT_W-1:0] norm_sat(input logic [ACC_W-1:0] a);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shf;
    prod = PW'($signed(a)) * PW'(MUL_C);
    shf  = prod >>> SHIFT;
    if ((&shf[PW-1:OUT_W-1]) || !(|shf[PW-1:OUT_W-1]))
      return shf[OUT_W-1:0];
    else if (shf[PW-1])
      return {1'b1, {(OUT_W-1){1'b0}}};
    else
      return {1'b0, {(OUT_W-1){1'b1}}};
  endfunction

  assign y = norm_sat(v);
endmodule

// File: rtl/cicdec_top.sv
module cicdec_top #(
  parameter int unsigned IN_W       = cic_pkg::CIC_IN_W,
  parameter int unsigned ACC_W      = cic_pkg::CIC_ACC_W,
  parameter int unsigned STAGES     = cic_pkg::CIC_STAGES,
  parameter int unsigned RATIO      = cic_pkg::CIC_RATIO,
  parameter int unsigned NORM_MUL   = cic_pkg::CIC_NORM_MUL,
  parameter int unsigned NORM_SHIFT = cic_pkg::CIC_NORM_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cic_en,
  input  logic signed [IN_W-1:0] din,
  output logic signed [IN_W-1:0] dout,
  output logic                   dout_vld
);
  // named internal events, observed by the bound checker
  logic             dec_stb;
  logic [ACC_W-1:0] integ_out;
  logic [ACC_W-1:0] comb_q;
  logic             comb_vld;
  logic [IN_W-1:0]  scaled;

  cic_integ_chain #(.IN_W(IN_W), .ACC_W(ACC_W), .N(STAGES)) u_integ (
    .clk(clk), .rst_n(rst_n), .run(cic_en), .din(din), .acc_out(integ_out)
  );

  cic_dec_ctr #(.R(RATIO)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(cic_en), .stb(dec_stb)
  );

  cic_comb_chain #(.ACC_W(ACC_W), .N(STAGES)) u_comb (
    .clk(clk), .rst_n(rst_n), .run(cic_en), .stb(dec_stb),
    .acc_in(integ_out), .comb_q(comb_q), .comb_vld(comb_vld)
  );

  cic_scale #(.ACC_W(ACC_W), .OUT_W(IN_W), .MUL(NORM_MUL), .SHIFT(NORM_SHIFT)) u_scale (
    .v(comb_q), .y(scaled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else if (!cic_en) begin
      dout     <= din;
      dout_vld <= 1'b1;
    end else begin
      dout_vld <= comb_vld;
      if (comb_vld) dout <= $signed(scaled);
    end
  end
endmodule

// File: rtl/cicdec_chk.sv
module cicdec_chk #(
  parameter int unsigned IN_W  = 14,
  parameter int unsigned ACC_W = 64,
  parameter int unsigned R     = 125
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cic_en,
  input logic [IN_W-1:0]  din,
  input logic [IN_W-1:0]  dout,
  input logic             dout_vld,
  input logic             dec_stb,
  input logic             comb_vld,
  input logic [ACC_W-1:0] comb_q
);
  localparam int unsigned GW = $clog2(R) + 1;

  logic [GW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap <= '0;
    else if (!cic_en || dec_stb) gap <= '0;
    else                       gap <= gap + 1'b1;
  end

  // R2
  stb_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cic_en |-> (dec_stb == (gap == GW'(R - 1))));
  // R2
  stb_to_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cic_en && dec_stb) |=> comb_vld);
  // R2
  comb_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cic_en && comb_vld) |=> dout_vld);
  // R2
  vld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_vld && $past(cic_en)) |-> $past(comb_vld));
  // R4
  comb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cic_en && !dec_stb) |=> $stable(comb_q));
  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cic_en |=> (dout_vld && dout == $past(din)));
  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cic_en |=> !comb_vld);
endmodule

bind cicdec_top cicdec_chk #(.IN_W(IN_W), .ACC_W(ACC_W), .R(RATIO)) chk_i (
  .clk(clk), .rst_n(rst_n), .cic_en(cic_en), .din(din), .dout(dout),
  .dout_vld(dout_vld), .dec_stb(dec_stb), .comb_vld(comb_vld), .comb_q(comb_q)
);

// File: tb/cicdec_top_tb_top.sv
module cicdec_top_tb_top;
  localparam int RR = 125;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cic_en;
  logic signed [13:0] din;
  logic signed [13:0] dout;
  logic dout_vld;

  always #10 clk = ~clk;

  cicdec_top dut_i (
    .clk(clk), .rst_n(rst_n), .cic_en(cic_en), .din(din),
    .dout(dout), .dout_vld(dout_vld)
  );

  typedef struct {
    int     val;
    longint due;
    string  tag;
  } exp_t;

  exp_t   sb_q[$];
  int     n_vec = 0;
  int     n_bad = 0;
  longint cyc = 0;
  bit     fin = 1'b0;

  // reference model: six cascaded 125-sample running sums
  longint hist [NS][RR];
  longint rsum [NS];
  longint ydl [8];
  int     pos;
  int unsigned lfsr = 32'h1bad5eed;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_norm(longint y);
    logic signed [127:0] p, d, q;
    p = y;
    p = p * 128'sd302231;
    d = 128'sd1 <<< 60;
    q = p / d;
    if (p < 0 && q * d != p) q = q - 1;
    if (q > 8191)  return 8191;
    if (q < -8192) return -8192;
    return int'(q);
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < NS; s++) begin
      rsum[s] = 0;
      for (int j = 0; j < RR; j++) hist[s][j] = 0;
    end
    for (int j = 0; j < 8; j++) ydl[j] = 0;
    pos = 0;
  endfunction

  function automatic longint model_step(int x);
    longint v;
    v = x;
    for (int s = 0; s < NS; s++) begin
      rsum[s] = rsum[s] + v - hist[s][pos];
      hist[s][pos] = v;
      v = rsum[s];
    end
    pos = (pos + 1) % RR;
    return v;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // monitor: pops each expected item exactly at its due cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !fin) begin
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        exp_t it;
        it = sb_q.pop_front();
        n_vec++;
        if (dout_vld !== 1'b1 || int'(dout) != it.val) begin
          n_bad++;
          $display("FAIL %s: vld=%0b dout=%0d, expected vld=1 dout=%0d", it.tag, dout_vld, dout, it.val);
        end
      end else if (dout_vld === 1'b1) begin
        n_vec++;
        n_bad++;
        $display("FAIL R2: vld=1 dout=%0d at cycle %0d, expected no valid", dout, cyc);
      end
    end
  end

  // called at a negedge; drives one sample per cycle
  task automatic run_bypass(int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      cic_en = 1'b0;
      din    = $signed(lfsr[13:0]);
      e.val = int'($signed(lfsr[13:0])); e.due = cyc + 1; e.tag = "R6";
      sb_q.push_back(e);
      @(negedge clk);
    end
  endtask

  // mode 0: constant amp, 1: pseudo-random, 2: square wave of amp
  task automatic run_filter(int n, int mode, int amp, string tag, bit const_chk);
    model_clear();
    for (int i = 0; i < n; i++) begin
      int x;
      longint y;
      if (mode == 0) x = amp;
      else if (mode == 1) begin
        lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
        x = int'($signed(lfsr[13:0]));
      end else x = ((i / 40) % 2 == 1) ? amp : -amp;
      cic_en = 1'b1;
      din    = 14'(x);
      y = model_step(x);
      ydl[i % 8] = y;
      if (i % RR == RR - 1) begin
        exp_t e;
        e.val = ref_norm(ydl[(i - 6) % 8]); e.due = cyc + 2; e.tag = tag;
        sb_q.push_back(e);
      end
      @(negedge clk);
    end
    if (const_chk) begin
      int ex;
      ex = (amp > 0) ? amp - 1 : amp;
      n_vec++;
      if (int'(dout) != ex) begin
        n_bad++;
        $display("FAIL R3: settled dout=%0d for constant %0d, expected %0d", dout, amp, ex);
      end
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    cic_en = 1'b0;
    din    = 14'sd1234;
    repeat (3) @(negedge clk);
    n_vec++;
    if (dout !== 14'sd0 || dout_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: dout=%0d vld=%0b in reset, expected dout=0 vld=0", dout, dout_vld);
    end
    rst_n = 1'b1;
    run_bypass(12);
    run_filter(RR * 7 + 30, 0, 1000, "R4", 1'b1);
    run_bypass(15);
    run_filter(RR * 7 + 30, 0, -1000, "R7", 1'b1);
    run_bypass(5);
    run_filter(RR * 7 + 30, 0, 1, "R7", 1'b1);
    run_bypass(5);
    run_filter(RR * 7 + 30, 0, 8191, "R4", 1'b1);
    run_bypass(5);
    run_filter(RR * 24 + 30, 0, -8192, "R5", 1'b1);
    run_bypass(5);
    run_filter(RR * 10 + 30, 1, 0, "R4", 1'b0);
    run_bypass(5);
    run_filter(RR * 10 + 30, 2, 8000, "R4", 1'b0);
    run_bypass(10);
    run_filter(30, 0, 0, "R2", 1'b0);
    n_vec++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d expected outputs never seen, expected 0", sb_q.size());
    end
    fin = 1'b1;
    // asynchronous reset in mid-cycle (R1)
    #3 rst_n = 1'b0;
    #2;
    n_vec++;
    if (dout !== 14'sd0 || dout_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: dout=%0d vld=%0b after async reset, expected 0 0", dout, dout_vld);
    end
    summary();
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!fin) begin
      fin = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run not finished, expected completion");
      summary();
      $finish;
    end
  end
endmodule